// File: doc/BRIEF.md
# Power Mode Peripheral Clock Gating Controller

This block decides, cycle by cycle, which peripheral clocks and whether the processor and memory clock may run. It tracks three power modes: Run, Sleep and Deep-Sleep. For each mode, software provides a mask with one bit per peripheral. The block picks one of these masks from the current mode and an auto-gating switch. When auto-gating is off, the Run mask applies in every mode.

A wait-for-interrupt request moves the block from Run into one of the two sleep modes. The deep-sleep enable bit chooses which one. While either sleep mode is active, the core clock enable is low. A pending interrupt brings the block back to Run. A deep-sleep indication is driven out for a clock selection unit to use.

All enables come straight from flops that share one next-state decision. Each enable drives an integrated clock-gating cell directly. These outputs change only at a rising clock edge, one cycle after the inputs that caused the change.

Top module: `pmcg_top`

## Requirements
- R1: While reset is active, and for two cycles after it is released, core_clk_en is 1, periph_clk_en is all zeros and deep_sleep is 0; the block is in Run mode.
- R2: In Run mode, core_clk_en is 1, deep_sleep is 0, and periph_clk_en equals the run_mask sampled at the previous rising edge.
- R3: In Run mode, a rising edge with wfi_req=1, deep_sleep_en=0 and irq_pending=0 enters Sleep: afterwards core_clk_en=0 and deep_sleep=0.
- R4: In Run mode, a rising edge with wfi_req=1, deep_sleep_en=1 and irq_pending=0 enters Deep-Sleep: afterwards core_clk_en=0 and deep_sleep=1.
- R5: In Sleep mode, periph_clk_en follows sleep_mask when auto_gate_en=1 and run_mask when auto_gate_en=0, sampled at the previous edge.
- R6: In Deep-Sleep mode, periph_clk_en follows deep_mask when auto_gate_en=1 and run_mask when auto_gate_en=0, sampled at the previous edge.
- R7: In either sleep mode, a rising edge with irq_pending=1 returns the block to Run: afterwards core_clk_en=1, deep_sleep=0 and periph_clk_en equals run_mask.
- R8: In Run mode, wfi_req is ignored while irq_pending=1, and the block stays in Run.
- R9: No output changes between rising edges, even when a mask or control input changes in the middle of a cycle.
- R10: In a sleep mode with irq_pending=0, the block keeps its mode. A further wfi_req or a change of deep_sleep_en does not move it between Sleep and Deep-Sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock of the controller |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| run_mask | input | NUM_PERIPH | Peripheral gating mask for Run mode (1 = clocked) |
| sleep_mask | input | NUM_PERIPH | Peripheral gating mask for Sleep mode |
| deep_mask | input | NUM_PERIPH | Peripheral gating mask for Deep-Sleep mode |
| auto_gate_en | input | 1 | 1 = the sleep modes use their own masks; 0 = the Run mask applies everywhere |
| deep_sleep_en | input | 1 | Chooses Deep-Sleep (1) or Sleep (0) on a wait-for-interrupt request |
| wfi_req | input | 1 | Wait-for-interrupt request from the processor |
| irq_pending | input | 1 | An enabled interrupt is pending |
| periph_clk_en | output | NUM_PERIPH | Per-peripheral clock enables |
| core_clk_en | output | 1 | Processor and memory clock enable |
| deep_sleep | output | 1 | High while in Deep-Sleep mode |

## Verification
Each sleep mode is tested with auto-gating both on and off. Auto-gating is also switched while a sleep mode is held. A design that hard-wires a mode to its own mask, or that treats Deep-Sleep with auto-gating off like Sleep, would show the wrong peripheral enables. The bench raises wfi_req while an interrupt is pending, and again while already asleep with the deep-sleep bit flipped. A controller that lets a request win over a pending interrupt, or that moves between the two sleep modes, would leave the core clock off or change the deep-sleep indication. Masks are changed just after a falling edge, and the outputs are checked before the next rising edge. An enable path with no register would pass the change through mid-cycle.

// File: rtl/pmcg_pkg.sv
package pmcg_pkg;
  typedef enum logic [1:0] {
    PM_RUN   = 2'b00,
    PM_SLEEP = 2'b01,
    PM_DEEP  = 2'b10
  } pm_mode_e;
endpackage

// File: rtl/pmcg_rst_sync.sv
module pmcg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pmcg_mode_fsm.sv
module pmcg_mode_fsm
  import pmcg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wfi_req,
  input  logic     deep_sleep_en,
  input  logic     irq_pending,
  output pm_mode_e mode_d
);
  pm_mode_e mode_q;

  // Next-state decision: Run can only leave on a request with no pending
  // interrupt; sleep modes can only leave on an interrupt.
  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      PM_RUN: begin
        if (wfi_req && !irq_pending)
          mode_d = deep_sleep_en ? PM_DEEP : PM_SLEEP;
      end
      PM_SLEEP, PM_DEEP: begin
        if (irq_pending) mode_d = PM_RUN;
      end
      default: mode_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= PM_RUN;
    else        mode_q <= mode_d;
  end
endmodule

// File: rtl/pmcg_mask_sel.sv
module pmcg_mask_sel
  import pmcg_pkg::*;
#(
  parameter int NUM_PERIPH = 8
) (
  input  pm_mode_e              mode,
  input  logic                  auto_gate_en,
  input  logic [NUM_PERIPH-1:0] run_mask,
  input  logic [NUM_PERIPH-1:0] sleep_mask,
  input  logic [NUM_PERIPH-1:0] deep_mask,
  output logic [NUM_PERIPH-1:0] sel_mask
);
  always_comb begin
    sel_mask = run_mask;
    if (auto_gate_en) begin
      unique case (mode)
        PM_SLEEP: sel_mask = sleep_mask;
        PM_DEEP:  sel_mask = deep_mask;
        default:  sel_mask = run_mask;
      endcase
    end
  end
endmodule

// File: rtl/pmcg_gate_reg.sv
module pmcg_gate_reg
  import pmcg_pkg::*;
#(
  parameter int NUM_PERIPH = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  pm_mode_e              mode_d,
  input  logic [NUM_PERIPH-1:0] sel_mask,
  output logic [NUM_PERIPH-1:0] periph_clk_en,
  output logic                  core_clk_en,
  output logic                  deep_sleep
);
  logic core_d;
  logic deep_d;

  always_comb begin
    core_d = (mode_d == PM_RUN);
    deep_d = (mode_d == PM_DEEP);
  end

  for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_en
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) periph_clk_en[i] <= 1'b0;
      else        periph_clk_en[i] <= sel_mask[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_clk_en <= 1'b1;
      deep_sleep  <= 1'b0;
    end else begin
      core_clk_en <= core_d;
      deep_sleep  <= deep_d;
    end
  end
endmodule

// File: rtl/pmcg_top.sv
module pmcg_top
  import pmcg_pkg::*;
#(
  parameter int NUM_PERIPH = 8,
  parameter int RST_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PERIPH-1:0] run_mask,
  input  logic [NUM_PERIPH-1:0] sleep_mask,
  input  logic [NUM_PERIPH-1:0] deep_mask,
  input  logic                  auto_gate_en,
  input  logic                  deep_sleep_en,
  input  logic                  wfi_req,
  input  logic                  irq_pending,
  output logic [NUM_PERIPH-1:0] periph_clk_en,
  output logic                  core_clk_en,
  output logic                  deep_sleep
);
  logic                  rst_sync_n;
  pm_mode_e              mode_d;
  logic [NUM_PERIPH-1:0] sel_mask;

  pmcg_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pmcg_mode_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .wfi_req       (wfi_req),
    .deep_sleep_en (deep_sleep_en),
    .irq_pending   (irq_pending),
    .mode_d        (mode_d)
  );

  // The mask is chosen from the next mode so that mode and enables move
  // together on the same edge.
  pmcg_mask_sel #(.NUM_PERIPH(NUM_PERIPH)) u_sel (
    .mode         (mode_d),
    .auto_gate_en (auto_gate_en),
    .run_mask     (run_mask),
    .sleep_mask   (sleep_mask),
    .deep_mask    (deep_mask),
    .sel_mask     (sel_mask)
  );

  pmcg_gate_reg #(.NUM_PERIPH(NUM_PERIPH)) u_gate (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .mode_d        (mode_d),
    .sel_mask      (sel_mask),
    .periph_clk_en (periph_clk_en),
    .core_clk_en   (core_clk_en),
    .deep_sleep    (deep_sleep)
  );
endmodule

// File: rtl/pmcg_checker.sv
module pmcg_checker #(
  parameter int NUM_PERIPH = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM_PERIPH-1:0] run_mask,
  input logic [NUM_PERIPH-1:0] sleep_mask,
  input logic [NUM_PERIPH-1:0] deep_mask,
  input logic                  auto_gate_en,
  input logic                  deep_sleep_en,
  input logic                  wfi_req,
  input logic                  irq_pending,
  input logic [NUM_PERIPH-1:0] periph_clk_en,
  input logic                  core_clk_en,
  input logic                  deep_sleep
);
  p_run_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (core_clk_en && !(wfi_req && !irq_pending)) |=>
      (core_clk_en && !deep_sleep && periph_clk_en == $past(run_mask)));

  p_sleep_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (core_clk_en && wfi_req && !deep_sleep_en && !irq_pending) |=>
      (!core_clk_en && !deep_sleep));

  p_deep_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (core_clk_en && wfi_req && deep_sleep_en && !irq_pending) |=>
      (!core_clk_en && deep_sleep));

  p_sleep_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_clk_en && !deep_sleep && !irq_pending) |=>
      (periph_clk_en == ($past(auto_gate_en) ? $past(sleep_mask) : $past(run_mask))));

  p_deep_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (deep_sleep && !irq_pending) |=>
      (periph_clk_en == ($past(auto_gate_en) ? $past(deep_mask) : $past(run_mask))));

  p_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_clk_en && irq_pending) |=> (core_clk_en && !deep_sleep));

  p_wfi_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (core_clk_en && irq_pending) |=> core_clk_en);

  p_mode_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_clk_en && !irq_pending) |=> (!core_clk_en && $stable(deep_sleep)));
endmodule

bind pmcg_top pmcg_checker #(.NUM_PERIPH(NUM_PERIPH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .run_mask      (run_mask),
  .sleep_mask    (sleep_mask),
  .deep_mask     (deep_mask),
  .auto_gate_en  (auto_gate_en),
  .deep_sleep_en (deep_sleep_en),
  .wfi_req       (wfi_req),
  .irq_pending   (irq_pending),
  .periph_clk_en (periph_clk_en),
  .core_clk_en   (core_clk_en),
  .deep_sleep    (deep_sleep)
);

// File: tb/pmcg_top_tb.sv
`timescale 1ns/1ps
module pmcg_top_tb;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] run_mask, sleep_mask, deep_mask;
  logic         auto_gate_en, deep_sleep_en, wfi_req, irq_pending;
  logic [N-1:0] periph_clk_en;
  logic         core_clk_en, deep_sleep;

  int n_cmp = 0;
  int n_bad = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;
  string cur_req = "R1";

  // Behavioural reference: 0 = Run, 1 = Sleep, 2 = Deep-Sleep
  int           m_mode;
  int           m_cnt;
  logic [N-1:0] m_periph;
  logic         m_core, m_deep;

  always #2 clk = ~clk;

  pmcg_top #(.NUM_PERIPH(N)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .run_mask(run_mask), .sleep_mask(sleep_mask), .deep_mask(deep_mask),
    .auto_gate_en(auto_gate_en), .deep_sleep_en(deep_sleep_en),
    .wfi_req(wfi_req), .irq_pending(irq_pending),
    .periph_clk_en(periph_clk_en), .core_clk_en(core_clk_en),
    .deep_sleep(deep_sleep)
  );

  always @(posedge clk) begin
    int nm;
    if (!rst_n) begin
      m_mode <= 0; m_cnt <= 0; m_periph <= '0; m_core <= 1'b1; m_deep <= 1'b0;
    end else if (m_cnt < 2) begin
      m_cnt <= m_cnt + 1;
    end else begin
      nm = m_mode;
      if (m_mode == 0) begin
        if (wfi_req && !irq_pending) nm = deep_sleep_en ? 2 : 1;
      end else if (irq_pending) nm = 0;
      m_mode   <= nm;
      m_core   <= (nm == 0);
      m_deep   <= (nm == 2);
      m_periph <= (nm == 0 || !auto_gate_en) ? run_mask :
                  (nm == 1) ? sleep_mask : deep_mask;
    end
  end

  task automatic check(string req, logic [N-1:0] ep, logic ec, logic ed);
    n_cmp++;
    if (periph_clk_en !== ep || core_clk_en !== ec || deep_sleep !== ed) begin
      n_bad++;
      $display("FAIL %s: got periph=%h core=%b deep=%b expected periph=%h core=%b deep=%b",
               req, periph_clk_en, core_clk_en, deep_sleep, ep, ec, ed);
    end
  endtask

  always @(negedge clk) if (cmp_on) check(cur_req, m_periph, m_core, m_deep);

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 20000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    run_mask = 8'hA5; sleep_mask = 8'h3C; deep_mask = 8'h81;
    auto_gate_en = 1'b0; deep_sleep_en = 1'b0; wfi_req = 1'b0; irq_pending = 1'b0;
    tick(4);
    check("R1", 8'h00, 1'b1, 1'b0);
    rst_n = 1'b1;
    tick(1);
    check("R1", 8'h00, 1'b1, 1'b0);  // still in synchronised reset
    cmp_on = 1'b1;
    tick(2);
    // R2: Run follows the Run mask
    cur_req = "R2";
    check("R2", 8'hA5, 1'b1, 1'b0);
    run_mask = 8'h5A; tick(1);
    check("R2", 8'h5A, 1'b1, 1'b0);
    // R9: mid-cycle mask change does not reach the outputs before the edge
    cur_req = "R9";
    run_mask = 8'hF0; #1;
    check("R9", 8'h5A, 1'b1, 1'b0);
    tick(1);
    check("R9", 8'hF0, 1'b1, 1'b0);
    // R3 then R5 with auto-gating on
    cur_req = "R3";
    auto_gate_en = 1'b1; wfi_req = 1'b1; tick(1);
    wfi_req = 1'b0;
    check("R3", 8'h3C, 1'b0, 1'b0);
    cur_req = "R5";
    tick(2);
    check("R5", 8'h3C, 1'b0, 1'b0);
    sleep_mask = 8'h0F; tick(1);
    check("R5", 8'h0F, 1'b0, 1'b0);
    auto_gate_en = 1'b0; tick(1);
    check("R5", 8'hF0, 1'b0, 1'b0);
    // R10: a further request with deep-sleep selected keeps Sleep
    cur_req = "R10";
    auto_gate_en = 1'b1; deep_sleep_en = 1'b1; wfi_req = 1'b1; tick(2);
    wfi_req = 1'b0;
    check("R10", 8'h0F, 1'b0, 1'b0);
    // R7: interrupt wakes from Sleep
    cur_req = "R7";
    irq_pending = 1'b1; tick(1);
    irq_pending = 1'b0;
    check("R7", 8'hF0, 1'b1, 1'b0);
    // R4 then R6
    cur_req = "R4";
    wfi_req = 1'b1; tick(1);
    wfi_req = 1'b0;
    check("R4", 8'h81, 1'b0, 1'b1);
    cur_req = "R6";
    deep_mask = 8'h42; tick(1);
    check("R6", 8'h42, 1'b0, 1'b1);
    auto_gate_en = 1'b0; tick(1);
    check("R6", 8'hF0, 1'b0, 1'b1);
    cur_req = "R10";
    deep_sleep_en = 1'b0; wfi_req = 1'b1; tick(2);
    wfi_req = 1'b0;
    check("R10", 8'hF0, 1'b0, 1'b1);
    cur_req = "R7";
    irq_pending = 1'b1; run_mask = 8'h11; tick(1);
    check("R7", 8'h11, 1'b1, 1'b0);
    // R8: request while an interrupt is pending is ignored
    cur_req = "R8";
    wfi_req = 1'b1; deep_sleep_en = 1'b1; tick(3);
    check("R8", 8'h11, 1'b1, 1'b0);
    irq_pending = 1'b0; tick(1);
    wfi_req = 1'b0;
    check("R4", 8'h11, 1'b0, 1'b1);
    irq_pending = 1'b1; tick(1);
    irq_pending = 1'b0;
    check("R7", 8'h11, 1'b1, 1'b0);
    tick(3);
    finish_run();
  end
endmodule